// File: doc/BRIEF.md
# Serial TDM Timeslot Transmitter with Strap-Selected Channel Group

This block places four 32-bit channel words onto a shared serial time-division bus. The bus carries sixteen 32-bit channels per frame, 512 bits in all, sent most significant bit first. Frames are marked by a frame-sync pulse at 8 kHz. The block clock is the bus bit clock, which runs at twice the data rate, so every data bit occupies two clock cycles and a frame spans 1024 cycles. A two-bit strap picks which group of four consecutive channels belongs to this device. During those channels the block drives the line. Outside them it releases the line.

The mode strap selects the driver style. In push-pull mode both logic levels are driven for the whole of an owned channel. In open-drain mode only zeros are driven, and ones are left to the external pull-up. On the board the mode pin is pulled low, so open-drain is the default. The block itself has no pull: a low level on `pp_mode` means open-drain.

Control is a two-state machine. `HUNT` is the state after reset, with the output released. The transition `LOCK` happens on the first frame-sync and moves the machine to `RUN`. In `RUN`, the transition `WRAP` free-runs the 1024-cycle count from one frame to the next. The transition `RESYNC` restarts the count on any sync. A sync that does not land on the last cycle of the count also flags a framing error.

Top module: `tdm_slot_tx`

## Requirements
- R1: After reset and until the first clock edge at which `fsync` is high, `dout_oe` is 0, `dout` is 1 and `frame_err` is 0.
- R2: The edge at which `fsync` is seen high launches frame bit 0. Frame bit n is launched at the 2n-th edge after that edge and holds for two cycles. Frame bit n belongs to channel n/32, at word bit position 31 - (n mod 32), so each word goes out most significant bit first.
- R3: With `slot_sel` = s (00, 01, 10 or 11), the owned channels are 4s to 4s+3. Channel 4s+k carries `ch_data[32k+31:32k]`.
- R4: With `pp_mode` = 1 (push-pull), `dout_oe` is 1 for the whole of an owned channel and `dout` equals the data bit.
- R5: With `pp_mode` = 0 (open-drain), during an owned channel `dout_oe` is 1 only while the data bit is 0, with `dout` = 0. For a 1 bit, `dout_oe` is 0 and `dout` is 1. Whenever `dout_oe` is 0, `dout` reads 1.
- R6: During channels that are not owned, `dout_oe` is 0 and `dout` is 1 in both modes.
- R7: An `fsync` seen in `RUN` when the count is not on the last cycle of the frame (cycle 1023) makes `frame_err` 1 for exactly the next cycle and restarts the frame from bit 0. A sync exactly 1024 cycles after the previous one, and the first sync after reset, give no error. A sync pulse longer than one cycle therefore reports an error.
- R8: Without further syncs, the frame repeats every 1024 cycles and no error is raised.
- R9: `slot_sel`, `pp_mode` and `ch_data` are sampled only at bit-launch edges. A change takes effect at the next launched bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, twice the data rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync | input | 1 | Frame-sync pulse, one cycle wide |
| slot_sel | input | 2 | Strap selecting the owned four-channel group |
| pp_mode | input | 1 | 1 = push-pull, 0 = open-drain |
| ch_data | input | 128 | Four 32-bit words, word k in bits [32k+31:32k] |
| dout | output | 1 | Serial data level |
| dout_oe | output | 1 | Output enable for the pad driver |
| frame_err | output | 1 | One-cycle pulse on a misplaced sync |

## Verification
If the frame counter is off by even one cycle, launches move to odd cycles. The output then changes on the edge where it should hold, and this shows within two cycles of the sync. A wrong group or lane decode shows as an enable in the wrong 32-bit window of the first frame. A corrupted state or wrap value shows up at the next on-time sync as a spurious `frame_err`, or as a missing one on a misplaced sync. The reference model tracks the count and the expected driver levels on every clock, so any of these faults is caught in the cycle it first appears.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
    // frame control states
    typedef enum logic {
        ST_HUNT = 1'b0,   // no sync seen yet, line released
        ST_RUN  = 1'b1    // counting bit-clock cycles inside a frame
    } tdm_state_e;
endpackage

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl
    import tdm_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int LAST  = 1023
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    output logic [CNT_W-1:0] nxt_cnt,
    output logic             nxt_run,
    output logic             frame_err
);
    tdm_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             err_d;

    // next-state and next-count logic
    always_comb begin
        state_d = state_q;
        nxt_cnt = cnt_q;
        err_d   = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (fsync) begin                  // LOCK
                    state_d = ST_RUN;
                    nxt_cnt = '0;
                end
            end
            ST_RUN: begin
                if (fsync) begin                  // RESYNC
                    nxt_cnt = '0;
                    err_d   = (cnt_q != CNT_W'(LAST));
                end else if (cnt_q == CNT_W'(LAST)) begin
                    nxt_cnt = '0;                 // WRAP
                end else begin
                    nxt_cnt = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_HUNT;
        endcase
    end

    assign nxt_run = (state_d == ST_RUN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_HUNT;
            cnt_q     <= '0;
            frame_err <= 1'b0;
        end else begin
            state_q   <= state_d;
            cnt_q     <= nxt_cnt;
            frame_err <= err_d;
        end
    end
endmodule

// File: rtl/tdm_slot_mux.sv
// Picks the bit for a frame bit index. CH_W, GRP_CH and NUM_GRP are powers of two.
module tdm_slot_mux #(
    parameter int CH_W    = 32,
    parameter int GRP_CH  = 4,
    parameter int NUM_GRP = 4,
    localparam int POS_W  = $clog2(CH_W),
    localparam int LANE_W = $clog2(GRP_CH),
    localparam int SEL_W  = $clog2(NUM_GRP),
    localparam int BIT_W  = POS_W + LANE_W + SEL_W
) (
    input  logic [BIT_W-1:0]       bit_idx,
    input  logic [SEL_W-1:0]       slot_sel,
    input  logic [GRP_CH*CH_W-1:0] ch_data,
    output logic                   owned,
    output logic                   bit_val
);
    logic [CH_W-1:0]   word [GRP_CH];
    logic [POS_W-1:0]  pos;
    logic [LANE_W-1:0] lane;
    logic [SEL_W-1:0]  grp;

    for (genvar g = 0; g < GRP_CH; g++) begin : g_word
        assign word[g] = ch_data[g*CH_W +: CH_W];
    end

    assign pos     = ~bit_idx[POS_W-1:0];           // MSB first
    assign lane    = bit_idx[POS_W +: LANE_W];
    assign grp     = bit_idx[POS_W+LANE_W +: SEL_W];
    assign owned   = (grp == slot_sel);
    assign bit_val = word[lane][pos];
endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
    import tdm_pkg::*;
#(
    parameter int CH_W    = 32,
    parameter int GRP_CH  = 4,
    parameter int NUM_GRP = 4,
    localparam int FRAME_BITS = CH_W * GRP_CH * NUM_GRP,
    localparam int FRAME_CLKS = 2 * FRAME_BITS,
    localparam int CNT_W      = $clog2(FRAME_CLKS),
    localparam int SEL_W      = $clog2(NUM_GRP)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fsync,
    input  logic [SEL_W-1:0]       slot_sel,
    input  logic                   pp_mode,
    input  logic [GRP_CH*CH_W-1:0] ch_data,
    output logic                   dout,
    output logic                   dout_oe,
    output logic                   frame_err
);
    logic [CNT_W-1:0] nxt_cnt;
    logic             nxt_run;
    logic             owned;
    logic             bit_val;
    logic             launch;

    tdm_frame_ctrl #(
        .CNT_W (CNT_W),
        .LAST  (FRAME_CLKS - 1)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .nxt_cnt   (nxt_cnt),
        .nxt_run   (nxt_run),
        .frame_err (frame_err)
    );

    tdm_slot_mux #(
        .CH_W    (CH_W),
        .GRP_CH  (GRP_CH),
        .NUM_GRP (NUM_GRP)
    ) u_mux (
        .bit_idx  (nxt_cnt[CNT_W-1:1]),
        .slot_sel (slot_sel),
        .ch_data  (ch_data),
        .owned    (owned),
        .bit_val  (bit_val)
    );

    // a new bit goes out when the next count is even
    assign launch = nxt_run && !nxt_cnt[0];

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout    <= 1'b1;
            dout_oe <= 1'b0;
        end else if (!nxt_run) begin
            dout    <= 1'b1;
            dout_oe <= 1'b0;
        end else if (launch) begin
            if (owned) begin
                dout    <= bit_val;
                dout_oe <= pp_mode | ~bit_val;
            end else begin
                dout    <= 1'b1;
                dout_oe <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tdm_slot_tx_chk.sv
module tdm_slot_tx_chk #(
    parameter int FRAME_CLKS = 1024,
    localparam int K_W = $clog2(FRAME_CLKS)
) (
    input logic clk,
    input logic rst_n,
    input logic fsync,
    input logic dout,
    input logic dout_oe,
    input logic frame_err
);
    logic           seen;
    logic [K_W-1:0] k;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= 1'b0;
            k    <= '0;
        end else if (fsync) begin
            seen <= 1'b1;
            k    <= '0;
        end else if (seen) begin
            k <= (k == K_W'(FRAME_CLKS - 1)) ? '0 : k + 1'b1;
        end
    end

    // R1
    idle_before_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |-> (!dout_oe && dout && !frame_err));

    // R5
    released_reads_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> dout);

    // R2
    hold_two_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !fsync && !k[0]) |=> ($stable(dout) && $stable(dout_oe)));

    // R7
    late_sync_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync && seen && k != K_W'(FRAME_CLKS - 1)) |=> frame_err);

    // R7
    ontime_sync_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync && seen && k == K_W'(FRAME_CLKS - 1)) |=> !frame_err);

    // R8
    err_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> $past(fsync));
endmodule

bind tdm_slot_tx tdm_slot_tx_chk #(.FRAME_CLKS(FRAME_CLKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fsync     (fsync),
    .dout      (dout),
    .dout_oe   (dout_oe),
    .frame_err (frame_err)
);

// File: tb/tdm_slot_tx_tb.sv
module tdm_slot_tx_tb;
    localparam int CLK_P = 10;
    localparam int FCLK  = 1024;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fsync = 1'b0;
    logic [1:0]   slot_sel = 2'd0;
    logic         pp_mode = 1'b0;
    logic [127:0] ch_data = '0;
    logic         dout, dout_oe, frame_err;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string phase = "R1";

    // reference model state
    int m_run = 0;
    int m_cnt = 0;
    bit e_dout = 1'b1;
    bit e_oe = 1'b0;
    bit e_err = 1'b0;
    bit e_owned = 1'b0;

    tdm_slot_tx u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .slot_sel  (slot_sel),
        .pp_mode   (pp_mode),
        .ch_data   (ch_data),
        .dout      (dout),
        .dout_oe   (dout_oe),
        .frame_err (frame_err)
    );

    always #(CLK_P/2) clk = ~clk;

    // cycle-by-cycle reference model, compared a quarter period after each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_cnt = 0; e_dout = 1'b1; e_oe = 1'b0; e_err = 1'b0; e_owned = 1'b0;
        end else begin
            e_err = 1'b0;
            if (fsync) begin
                e_err = (m_run != 0) && (m_cnt != FCLK - 1);
                m_cnt = 0;
                m_run = 1;
            end else if (m_run != 0) begin
                m_cnt = (m_cnt + 1) % FCLK;
            end
            if (m_run != 0 && (m_cnt % 2) == 0) begin
                int b, ch, wbit;
                bit v;
                b    = m_cnt / 2;
                ch   = b / 32;
                wbit = 31 - (b % 32);
                v    = ch_data[(ch % 4) * 32 + wbit];
                e_owned = ((ch / 4) == int'(slot_sel));
                if (e_owned) begin
                    e_dout = v;
                    e_oe   = pp_mode | ~v;
                end else begin
                    e_dout = 1'b1;
                    e_oe   = 1'b0;
                end
            end
        end
        #(CLK_P/4);
        if (rst_n) compare();
    end

    task automatic compare();
        string tag;
        if (frame_err !== e_err) tag = "R7";
        else if (m_run == 0) tag = "R1";
        else if (!e_owned) tag = "R6";
        else tag = phase;
        total++;
        if (dout !== e_dout || dout_oe !== e_oe || frame_err !== e_err) begin
            bad++;
            $display("FAIL %s cnt=%0d actual dout=%b oe=%b err=%b expected dout=%b oe=%b err=%b",
                     tag, m_cnt, dout, dout_oe, frame_err, e_dout, e_oe, e_err);
        end
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // start a frame at the current negedge; next sync comes n cycles later
    task automatic frame(input int n);
        fsync = 1'b1;
        @(negedge clk);
        fsync = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(dout_oe === 1'b0 && dout === 1'b1 && frame_err === 1'b0, "R1",
              {dout_oe, dout, frame_err}, 3'b010);
        rst_n = 1'b1;
        phase = "R1";
        repeat (30) @(negedge clk);

        // R2: bit timing, slot 0 push-pull
        phase = "R2";
        slot_sel = 2'd0; pp_mode = 1'b1;
        ch_data = {32'h0F0F_3C3C, 32'h1234_5678, 32'hFFFF_0000, 32'h8000_0001};
        fsync = 1'b1;
        @(negedge clk); fsync = 1'b0;
        check(dout === 1'b1 && dout_oe === 1'b1, "R2", {dout_oe, dout}, 2'b11);
        @(negedge clk);
        check(dout === 1'b1, "R2", dout, 1);
        @(negedge clk);
        check(dout === 1'b0, "R2", dout, 0);
        repeat (60) @(negedge clk);   // bit 31 of channel 0, launched at edge 62
        check(dout === 1'b1, "R2", dout, 1);
        repeat (1024 - 63) @(negedge clk);
        frame(FCLK);

        // R3: every group
        phase = "R3";
        for (int s = 0; s < 4; s++) begin
            slot_sel = 2'(s);
            ch_data = {32'hC001_D00D ^ 32'(s), 32'h5A5A_A5A5, 32'h0000_FFFF ^ 32'(s << 8), 32'h1357_9BDF};
            frame(FCLK);
        end

        // R4: push-pull
        phase = "R4";
        pp_mode = 1'b1; slot_sel = 2'd1;
        ch_data = {32'hA5C3_0FF0, 32'h0000_0000, 32'hFFFF_FFFF, 32'h6996_9669};
        frame(FCLK);

        // R5: open-drain
        phase = "R5";
        pp_mode = 1'b0; slot_sel = 2'd2;
        frame(FCLK);
        slot_sel = 2'd3;
        frame(FCLK);

        // R7: misplaced syncs
        phase = "R7";
        frame(500);
        frame(FCLK);
        frame(1100);
        fsync = 1'b1;
        @(negedge clk);               // two-cycle sync
        frame(FCLK);
        frame(FCLK);

        // R8: flywheel over three frames
        phase = "R8";
        frame(3 * FCLK);

        // R9: straps and data change mid-frame
        phase = "R9";
        fsync = 1'b1;
        @(negedge clk); fsync = 1'b0;
        for (int i = 1; i < FCLK; i++) begin
            if (i % 37 == 0) begin
                pp_mode  = ~pp_mode;
                slot_sel = slot_sel + 2'd1;
                ch_data  = {ch_data[126:0], ch_data[127] ^ ch_data[5]};
            end
            @(negedge clk);
        end
        frame(FCLK);
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule